// File: doc/BRIEF.md
# Register-File Block Transfer Sequencer

This block carries out a single instruction that moves the whole general-purpose register file to or from main memory. When the instruction is accepted, it forms a base byte address from a register value plus a sign-extended 16-bit offset. It then steps through registers 1 to 31 in ascending order. Entry i sits at byte address base + 4*i, and register 0 is never touched. The memory holds 2048 words of 32 bits. The word index is the byte address divided by four, wrapping modulo 2048.

In store direction, one register is read and written to memory every cycle. In load direction, the memory reads are pipelined. The read for entry i is issued in one cycle, and its data is written into register i in the next. A load therefore takes one cycle more than a store. The surrounding core drives a start strobe together with the opcode and operands. It then waits on busy, and done marks completion.

Top module: `rfxfer_seq`

## Requirements
- R1: After synchronous reset, busy, done, mem_we and rf_we are all 0.
- R2: A start is accepted only while busy is 0 and only when opcode is 6'b011100 (load direction) or 6'b011110 (store direction). A start with any other opcode has no effect: busy stays 0 and neither memory nor the register file is written.
- R3: The base byte address is base_val plus imm sign-extended to 32 bits. Entry i uses byte address base + 4*i, and mem_addr carries bits [12:2] of that address. In the first busy cycle, mem_addr is the index of entry 1.
- R4: Registers are visited in ascending order from 1 to 31. rf_we is never 1 with rf_addr equal to 0.
- R5: Store direction: in each of the 31 cycles after acceptance, mem_we is 1, rf_addr is i, and mem_wdata equals rf_rdata of that same cycle. Afterwards memory word of entry i holds register i.
- R6: Load direction: mem_addr for entry i is presented in the i-th busy cycle. Memory returns its data one cycle later. In the following cycle, rf_we is 1, rf_addr is i and rf_wdata equals mem_rdata. This gives 31 register writes and no memory writes.
- R7: busy rises in the cycle after an accepted start. It stays high for 31 cycles in store direction and 32 cycles in load direction.
- R8: done is 1 for exactly one cycle, the cycle right after busy falls, and is 0 otherwise.
- R9: A start arriving while busy is ignored. The running transfer keeps its direction, base and length.
- R10: Word indices wrap from 2047 to 0 within one transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a transfer |
| opcode | input | 6 | Instruction opcode selecting direction |
| base_val | input | 32 | Value of the base register |
| imm | input | 16 | Signed address offset |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | 11 | Memory word index |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after mem_addr |
| rf_addr | output | 5 | Register-file address for read or write |
| rf_we | output | 1 | Register-file write enable |
| rf_wdata | output | 32 | Register-file write data |
| rf_rdata | input | 32 | Register-file read data, same cycle as rf_addr |

## Verification
On every cycle, the assertions check the following:
- done never repeats and always follows a busy cycle.
- Register 0 is never written.
- A memory write and a register write never happen together.
- The register index and the memory index advance by exactly one per cycle, wrapping across the end of memory.
- The direction does not change mid-transfer.

Only the bench scenarios can show that the final memory and register contents match base + 4*i for a given offset. The same holds for exact busy lengths, for bad opcodes leaving everything untouched, and for a second start in mid-transfer not disturbing the result.

// File: rtl/rfxfer_pkg.sv
package rfxfer_pkg;
    localparam int DATA_W = 32;
    localparam int IMM_W  = 16;
    localparam int RF_AW  = 5;
    localparam int MEM_AW = 11;
    localparam int OP_W   = 6;

    localparam logic [OP_W-1:0] OP_BLK_LOAD  = 6'b011100;
    localparam logic [OP_W-1:0] OP_BLK_STORE = 6'b011110;

    localparam logic [RF_AW-1:0] FIRST_IDX = RF_AW'(1);
    localparam logic [RF_AW-1:0] LAST_IDX  = RF_AW'((1 << RF_AW) - 1);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } seq_state_e;

    typedef enum logic {
        DIR_LOAD  = 1'b0,
        DIR_STORE = 1'b1
    } xfer_dir_e;

    typedef struct packed {
        xfer_dir_e         dir;
        logic [MEM_AW-1:0] word;
    } xfer_cmd_t;

    function automatic logic [DATA_W-1:0] sext_imm(input logic [IMM_W-1:0] v);
        return {{(DATA_W-IMM_W){v[IMM_W-1]}}, v};
    endfunction

    function automatic logic [MEM_AW-1:0] word_of(input logic [DATA_W-1:0] byte_addr);
        return byte_addr[MEM_AW+1:2];
    endfunction
endpackage

// File: rtl/rfxfer_decode.sv
module rfxfer_decode
    import rfxfer_pkg::*;
(
    input  logic              start,
    input  logic [OP_W-1:0]   opcode,
    input  logic [DATA_W-1:0] base_val,
    input  logic [IMM_W-1:0]  imm,
    input  logic              busy,
    output logic              accept,
    output xfer_cmd_t         cmd
);
    logic              op_load;
    logic              op_store;
    logic [DATA_W-1:0] base_byte;

    always_comb begin
        op_load   = (opcode == OP_BLK_LOAD);
        op_store  = (opcode == OP_BLK_STORE);
        accept    = start && !busy && (op_load || op_store);
        base_byte = base_val + sext_imm(imm);
        cmd.dir   = op_store ? DIR_STORE : DIR_LOAD;
        cmd.word  = word_of(base_byte) + MEM_AW'(FIRST_IDX);
    end
endmodule

// File: rtl/rfxfer_ctrl.sv
module rfxfer_ctrl
    import rfxfer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  xfer_cmd_t         cmd,
    output seq_state_e        state,
    output xfer_dir_e         dir,
    output logic [RF_AW-1:0]  idx,
    output logic [MEM_AW-1:0] word,
    output logic              busy,
    output logic              done
);
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            dir   <= DIR_LOAD;
            idx   <= '0;
            word  <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        state <= ST_RUN;
                        dir   <= cmd.dir;
                        idx   <= FIRST_IDX;
                        word  <= cmd.word;
                    end
                end
                ST_RUN: begin
                    if (idx == LAST_IDX) begin
                        if (dir == DIR_STORE) begin
                            state <= ST_IDLE;
                            done  <= 1'b1;
                        end else begin
                            state <= ST_DRAIN;
                        end
                    end else begin
                        idx  <= idx + 1'b1;
                        word <= word + 1'b1;
                    end
                end
                ST_DRAIN: begin
                    state <= ST_IDLE;
                    done  <= 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state != ST_IDLE);

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    // R4
    idx_step_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && $past(state) == ST_RUN) |-> (idx == RF_AW'($past(idx) + 1'b1)));

    // R10
    word_step_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && $past(state) == ST_RUN) |-> (word == MEM_AW'($past(word) + 1'b1)));

    // R9
    dir_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(dir));
endmodule

// File: rtl/rfxfer_port.sv
module rfxfer_port
    import rfxfer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  seq_state_e        state,
    input  xfer_dir_e         dir,
    input  logic [RF_AW-1:0]  idx,
    input  logic [MEM_AW-1:0] word,
    output logic [MEM_AW-1:0] mem_addr,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [RF_AW-1:0]  rf_addr,
    output logic              rf_we,
    output logic [DATA_W-1:0] rf_wdata,
    input  logic [DATA_W-1:0] rf_rdata
);
    logic             run;
    logic             storing;
    logic             wb_vld;
    logic [RF_AW-1:0] wb_idx;

    assign run     = (state == ST_RUN);
    assign storing = run && (dir == DIR_STORE);

    // load writeback stage: data returns one cycle after the read issue
    always_ff @(posedge clk) begin
        if (rst) begin
            wb_vld <= 1'b0;
            wb_idx <= '0;
        end else begin
            wb_vld <= run && (dir == DIR_LOAD);
            wb_idx <= idx;
        end
    end

    always_comb begin
        mem_addr  = run ? word : '0;
        mem_we    = storing;
        mem_wdata = storing ? rf_rdata : '0;
        rf_we     = wb_vld;
        rf_wdata  = wb_vld ? mem_rdata : '0;
        if (storing)
            rf_addr = idx;
        else if (wb_vld)
            rf_addr = wb_idx;
        else
            rf_addr = '0;
    end

    // R4
    rf_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> (rf_addr != '0));

    // R6
    no_dual_write_chk: assert property (@(posedge clk) disable iff (rst)
        !(rf_we && mem_we));

    // R5
    store_stream_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $past(mem_we)) |-> (mem_addr == MEM_AW'($past(mem_addr) + 1'b1)));

    // R6
    load_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (rf_we && $past(rf_we)) |-> (rf_addr == RF_AW'($past(rf_addr) + 1'b1)));
endmodule

// File: rtl/rfxfer_seq.sv
module rfxfer_seq
    import rfxfer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [OP_W-1:0]   opcode,
    input  logic [DATA_W-1:0] base_val,
    input  logic [IMM_W-1:0]  imm,
    output logic              busy,
    output logic              done,
    output logic [MEM_AW-1:0] mem_addr,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [RF_AW-1:0]  rf_addr,
    output logic              rf_we,
    output logic [DATA_W-1:0] rf_wdata,
    input  logic [DATA_W-1:0] rf_rdata
);
    logic              accept;
    xfer_cmd_t         cmd;
    seq_state_e        state;
    xfer_dir_e         dir;
    logic [RF_AW-1:0]  idx;
    logic [MEM_AW-1:0] word;

    rfxfer_decode u_decode (
        .start    (start),
        .opcode   (opcode),
        .base_val (base_val),
        .imm      (imm),
        .busy     (busy),
        .accept   (accept),
        .cmd      (cmd)
    );

    rfxfer_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .accept (accept),
        .cmd    (cmd),
        .state  (state),
        .dir    (dir),
        .idx    (idx),
        .word   (word),
        .busy   (busy),
        .done   (done)
    );

    rfxfer_port u_port (
        .clk       (clk),
        .rst       (rst),
        .state     (state),
        .dir       (dir),
        .idx       (idx),
        .word      (word),
        .mem_addr  (mem_addr),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .rf_addr   (rf_addr),
        .rf_we     (rf_we),
        .rf_wdata  (rf_wdata),
        .rf_rdata  (rf_rdata)
    );

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_we && !rf_we));
endmodule

// File: tb/rfxfer_seq_bench.sv
`timescale 1ns/1ps
module rfxfer_seq_bench;
    localparam logic [5:0] OPL = 6'b011100;
    localparam logic [5:0] OPS = 6'b011110;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [5:0]  opcode;
    logic [31:0] base_val;
    logic [15:0] imm;
    logic        busy, done, mem_we, rf_we;
    logic [10:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata, rf_wdata, rf_rdata;
    logic [4:0]  rf_addr;

    logic [31:0] mem_m  [0:2047];
    logic [31:0] rf_m   [0:31];
    logic [31:0] exp_mem[0:2047];
    logic [31:0] exp_rf [0:31];

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    rfxfer_seq u_rfxfer_seq (
        .clk(clk), .rst(rst), .start(start), .opcode(opcode),
        .base_val(base_val), .imm(imm), .busy(busy), .done(done),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .rf_addr(rf_addr), .rf_we(rf_we),
        .rf_wdata(rf_wdata), .rf_rdata(rf_rdata)
    );

    // memory model: registered read, one cycle latency
    always @(posedge clk) begin
        if (mem_we) mem_m[mem_addr] <= mem_wdata;
        mem_rdata <= mem_m[mem_addr];
    end

    // register file model: combinational read, r0 reads zero
    assign rf_rdata = (rf_addr == 5'd0) ? 32'd0 : rf_m[rf_addr];
    always @(posedge clk) begin
        if (rf_we && rf_addr != 5'd0) rf_m[rf_addr] <= rf_wdata;
    end

    function automatic logic [10:0] exp_word(input logic [31:0] b,
                                             input logic [15:0] im, input int i);
        logic [31:0] a;
        a = b + {{16{im[15]}}, im} + 32'(4 * i);
        return a[12:2];
    endfunction

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic snapshot();
        for (int k = 0; k < 2048; k++) exp_mem[k] = mem_m[k];
        for (int k = 0; k < 32; k++) exp_rf[k] = rf_m[k];
    endtask

    task automatic compare_state(input string req);
        int bad_m = -1;
        int bad_r = -1;
        for (int k = 0; k < 2048; k++)
            if (bad_m < 0 && mem_m[k] !== exp_mem[k]) bad_m = k;
        for (int k = 1; k < 32; k++)
            if (bad_r < 0 && rf_m[k] !== exp_rf[k]) bad_r = k;
        if (bad_m < 0) check(req, 32'd0, 32'd0, "memory contents");
        else check(req, mem_m[bad_m], exp_mem[bad_m], $sformatf("memory word %0d", bad_m));
        if (bad_r < 0) check(req, 32'd0, 32'd0, "register contents");
        else check(req, rf_m[bad_r], exp_rf[bad_r], $sformatf("register %0d", bad_r));
    endtask

    task automatic run_op(input logic [5:0] op, input logic [31:0] b,
                          input logic [15:0] im, input bit disturb);
        int busy_n = 0;
        int mw_n = 0;
        int rw_n = 0;
        int r0_n = 0;
        bit st = (op == OPS);
        snapshot();
        for (int i = 1; i < 32; i++) begin
            if (st) exp_mem[exp_word(b, im, i)] = rf_m[i];
            else    exp_rf[i] = mem_m[exp_word(b, im, i)];
        end
        @(negedge clk);
        start = 1'b1; opcode = op; base_val = b; imm = im;
        @(negedge clk);
        start = 1'b0;
        while (busy && busy_n < 100) begin
            if (busy_n == 0)
                check("R3", 32'(mem_addr), 32'(exp_word(b, im, 1)), "first word index");
            busy_n++;
            if (mem_we) mw_n++;
            if (rf_we) rw_n++;
            if (rf_we && rf_addr == 5'd0) r0_n++;
            if (disturb && busy_n == 5) begin
                start = 1'b1;
                opcode = st ? OPL : OPS;
                base_val = $urandom;
                imm = 16'($urandom);
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        check("R7", busy_n, st ? 31 : 32, "busy cycles");
        check("R8", 32'(done), 32'd1, "done after busy");
        if (st) check("R5", mw_n, 31, "memory writes");
        else    check("R6", rw_n, 31, "register writes");
        check(st ? "R5" : "R6", st ? rw_n : mw_n, 0, "writes on the idle side");
        check("R4", r0_n, 0, "writes to register 0");
        @(negedge clk);
        check("R8", 32'(done), 32'd0, "done lasts one cycle");
        compare_state(disturb ? "R9" : (st ? "R5" : "R6"));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int k = 0; k < 2048; k++) mem_m[k] = $urandom;
        rf_m[0] = 32'd0;
        for (int k = 1; k < 32; k++) rf_m[k] = $urandom;
        rst = 1'b1; start = 1'b0; opcode = '0; base_val = '0; imm = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1", {28'd0, busy, done, mem_we, rf_we}, 32'd0, "outputs after reset");

        // R2 unknown opcode leaves everything untouched
        snapshot();
        start = 1'b1; opcode = 6'b011111; base_val = 32'h40; imm = 16'd0;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 3; k++) begin
            check("R2", {30'd0, busy, done}, 32'd0, "no start on bad opcode");
            @(negedge clk);
        end
        compare_state("R2");

        // directed cases
        run_op(OPS, 32'h0000_0100, 16'h0000, 1'b0);
        run_op(OPL, 32'h0000_0400, 16'h0000, 1'b0);
        run_op(OPS, 32'h0000_0100, 16'hFFF0, 1'b0);   // R3 negative offset
        run_op(OPL, 32'h0000_0103, 16'h0020, 1'b0);   // R3 low bits dropped
        run_op(OPS, 32'h0000_1FF0, 16'h0000, 1'b0);   // R10 wrap
        run_op(OPL, 32'hFFFF_FFF8, 16'h0004, 1'b0);   // R10 wrap, negative base
        run_op(OPS, 32'h0000_0800, 16'h0010, 1'b1);   // R9 start during busy
        run_op(OPL, 32'h0000_0A00, 16'h0008, 1'b1);   // R9 start during busy

        // constrained random operations
        for (int n = 0; n < 10; n++) begin
            logic [5:0] op;
            op = ($urandom % 2 == 0) ? OPL : OPS;
            run_op(op, $urandom, 16'($urandom), bit'($urandom % 3 == 0));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule